// File: doc/BRIEF.md
# Audio Frame Sequencer

This block turns a fast system clock into the slow control strobes that a four-voice sound generator needs. A programmable divider produces a step tick, at 512 Hz by default when the system clock runs at 4194304 Hz. Each tick moves an eight-phase state machine forward by one phase. The phase that the machine is leaving selects which one-cycle strobes fire. Length counters receive a strobe at 256 Hz, the frequency sweep unit at 128 Hz, and the volume envelope units at 64 Hz.

A power-enable level gates the whole sequencer. Any change of that level puts the phase and the divider back to zero. While power is low the sequencer holds at zero and stays silent. A period override input scales the step rate, which is how a tempo factor is applied. A value of zero on that input selects the default period.

The phase machine has eight named states, `PH0` to `PH7`. On a tick it takes the transitions `PH0→PH1`, `PH1→PH2`, and so on up to `PH6→PH7`, then the wrap transition `PH7→PH0`. Every state also has a clear transition to `PH0`, taken on reset, on a power change, or while power is low. Without a tick a state holds.

Top module: `sound_frame_seq`

## Requirements
- R1: The step tick period in clock cycles equals `period_ovr`. When `period_ovr` is 0, the period is the parameter `DEFAULT_PERIOD`, which defaults to 8192. With power steadily on, the counter fires a tick once it has counted `period-1` cycles since the last tick or clear.
- R2: On each tick, `phase` advances by one, from 0 to 7. After phase 7 it wraps to 0. Without a tick, `phase` holds.
- R3: `len_stb` is high exactly in the tick cycles whose current phase is 0, 2, 4 or 6.
- R4: `swp_stb` is high exactly in the tick cycles whose current phase is 2 or 6. `len_stb` is always high in those same cycles.
- R5: `env_stb` is high exactly in the tick cycle whose current phase is 7. It never coincides with `len_stb`.
- R6: In a cycle where `pwr_en` differs from its value in the previous cycle, no strobe fires. After that edge, both the phase and the divider are 0.
- R7: While `pwr_en` is low, `phase` is 0 after each edge and no strobe fires.
- R8: With `rst` high at a clock edge, `phase`, the divider and the stored power level all become 0. No strobe fires while `rst` is high.
- R9: Each strobe lasts a single clock cycle. No strobe is high in two consecutive cycles.
- R10: If `period_ovr` is lowered so that the count already meets or exceeds the new `period-1`, the tick fires in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_en | input | 1 | Sound power enable level |
| period_ovr | input | DIV_W (16) | Step period in clock cycles; 0 selects DEFAULT_PERIOD |
| len_stb | output | 1 | Length-counter strobe |
| swp_stb | output | 1 | Sweep strobe |
| env_stb | output | 1 | Envelope strobe |
| phase | output | 3 | Current sequencer phase |

## Verification
The sequencer is first run with short override periods (1, 4 and 3). These walk the full eight-phase cycle many times, which separates the phase decode of each strobe and the wrap from 7 to 0. Power is toggled both in the middle of a step and in the middle of a phase cycle. Held-off windows check that phase and divider restart from zero. Reset is applied mid-run, and the override is lowered below the running count to expose the tick-on-shrink case. One long run at the default period confirms the 8192-cycle spacing of phase changes.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [2:0] {
        PH0 = 3'd0, PH1 = 3'd1, PH2 = 3'd2, PH3 = 3'd3,
        PH4 = 3'd4, PH5 = 3'd5, PH6 = 3'd6, PH7 = 3'd7
    } seq_phase_e;

    typedef struct packed {
        logic len;
        logic swp;
        logic env;
    } seq_strobes_t;

endpackage

// File: rtl/sfs_divider.sv
module sfs_divider #(
    parameter int DIV_W          = 16,
    parameter int DEFAULT_PERIOD = 8192
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] period_ovr,
    output logic             tick
);
    localparam logic [DIV_W-1:0] DEF_P = DIV_W'(DEFAULT_PERIOD);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;
    logic [DIV_W-1:0] last_cnt;

    always_comb begin
        limit    = (period_ovr == '0) ? DEF_P : period_ovr;
        last_cnt = limit - 1'b1;
        tick     = run && !clr && (cnt >= last_cnt);
    end

    always_ff @(posedge clk) begin
        if (clr || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1
    cnt_restart_chk: assert property (@(posedge clk) disable iff (clr)
        (run && tick) |=> (cnt == '0));

endmodule

// File: rtl/sfs_phase_fsm.sv
module sfs_phase_fsm
    import sfs_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       adv,
    output logic [2:0] phase
);
    seq_phase_e state, state_nx;

    always_comb begin
        state_nx = state;
        if (clr) begin
            state_nx = PH0;
        end else if (adv) begin
            unique case (state)
                PH0: state_nx = PH1;
                PH1: state_nx = PH2;
                PH2: state_nx = PH3;
                PH3: state_nx = PH4;
                PH4: state_nx = PH5;
                PH5: state_nx = PH6;
                PH6: state_nx = PH7;
                PH7: state_nx = PH0;
                default: state_nx = PH0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state <= state_nx;
    end

    always_comb begin
        phase = 3'(state);
    end

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (clr)
        (adv && !clr) |=> (phase == 3'($past(phase) + 3'd1)));

endmodule

// File: rtl/sfs_strobe_dec.sv
module sfs_strobe_dec
    import sfs_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [2:0]   phase,
    output seq_strobes_t stb
);
    seq_strobes_t sel;

    always_comb begin
        sel = '0;
        unique case (seq_phase_e'(phase))
            PH0, PH4: sel.len = 1'b1;
            PH2, PH6: begin
                sel.len = 1'b1;
                sel.swp = 1'b1;
            end
            PH7:      sel.env = 1'b1;
            default:  sel = '0;
        endcase
        stb = tick ? sel : '0;
    end

    // R4
    swp_with_len_chk: assert property (@(posedge clk) disable iff (rst)
        stb.swp |-> stb.len);

    // R5
    env_alone_chk: assert property (@(posedge clk) disable iff (rst)
        stb.env |-> !stb.len);

endmodule

// File: rtl/sound_frame_seq.sv
module sound_frame_seq
    import sfs_pkg::*;
#(
    parameter int DIV_W          = 16,
    parameter int DEFAULT_PERIOD = 8192
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_en,
    input  logic [DIV_W-1:0] period_ovr,
    output logic             len_stb,
    output logic             swp_stb,
    output logic             env_stb,
    output logic [2:0]       phase
);
    logic         pwr_q;
    logic         pwr_edge;
    logic         clr;
    logic         run;
    logic         tick;
    seq_strobes_t stb;

    always_ff @(posedge clk) begin
        if (rst) pwr_q <= 1'b0;
        else     pwr_q <= pwr_en;
    end

    always_comb begin
        pwr_edge = pwr_en ^ pwr_q;
        clr      = rst || pwr_edge || !pwr_en;
        run      = pwr_en && pwr_q;
    end

    sfs_divider #(
        .DIV_W          (DIV_W),
        .DEFAULT_PERIOD (DEFAULT_PERIOD)
    ) u_div (
        .clk        (clk),
        .clr        (clr),
        .run        (run),
        .period_ovr (period_ovr),
        .tick       (tick)
    );

    sfs_phase_fsm u_fsm (
        .clk   (clk),
        .clr   (clr),
        .adv   (tick),
        .phase (phase)
    );

    sfs_strobe_dec u_dec (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .phase (phase),
        .stb   (stb)
    );

    always_comb begin
        len_stb = stb.len;
        swp_stb = stb.swp;
        env_stb = stb.env;
    end

    // R6
    pwr_edge_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_en != pwr_q) |=> (phase == 3'd0));

    // R7
    pwr_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> !(len_stb || swp_stb || env_stb));

    // R9
    len_single_chk: assert property (@(posedge clk) disable iff (rst)
        len_stb |=> !len_stb);

    // R9
    env_single_chk: assert property (@(posedge clk) disable iff (rst)
        env_stb |=> !env_stb);

endmodule

// File: tb/tb_sound_frame_seq.sv
module tb_sound_frame_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 16;
    localparam int DEF_P      = 8192;
    localparam int WATCHDOG   = 190000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwr_en = 1'b0;
    logic [DIV_W-1:0] period_ovr = '0;
    logic             len_stb, swp_stb, env_stb;
    logic [2:0]       phase;

    int    vectors = 0;
    int    fails   = 0;
    int    cycles  = 0;
    string cur_req = "R8";

    int m_cnt = 0, m_ph = 0, m_prev = 0;
    int last_change = 0, change_gap = 0;

    sound_frame_seq #(.DIV_W(DIV_W), .DEFAULT_PERIOD(DEF_P)) dut (
        .clk(clk), .rst(rst), .pwr_en(pwr_en), .period_ovr(period_ovr),
        .len_stb(len_stb), .swp_stb(swp_stb), .env_stb(env_stb), .phase(phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int lim();
        return (period_ovr == 0) ? DEF_P : int'(period_ovr);
    endfunction

    function automatic bit exp_tick();
        return !rst && pwr_en && (m_prev == 1) && (m_cnt >= lim() - 1);
    endfunction

    always @(negedge clk) begin
        bit t, el, es, ee;
        t  = exp_tick();
        el = t && (m_ph % 2 == 0);
        es = t && (m_ph == 2 || m_ph == 6);
        ee = t && (m_ph == 7);
        vectors++;
        if (phase !== 3'(m_ph)) begin
            fails++; $display("FAIL %s/R2 phase act=%0d exp=%0d t=%0t", cur_req, phase, m_ph, $time);
        end
        if (len_stb !== el) begin
            fails++; $display("FAIL %s/R3 len act=%0b exp=%0b t=%0t", cur_req, len_stb, el, $time);
        end
        if (swp_stb !== es) begin
            fails++; $display("FAIL %s/R4 swp act=%0b exp=%0b t=%0t", cur_req, swp_stb, es, $time);
        end
        if (env_stb !== ee) begin
            fails++; $display("FAIL %s/R5 env act=%0b exp=%0b t=%0t", cur_req, env_stb, ee, $time);
        end
    end

    always @(posedge clk) begin
        bit t;
        int old_ph;
        t = exp_tick();
        old_ph = m_ph;
        cycles++;
        if (rst) begin
            m_cnt = 0; m_ph = 0; m_prev = 0;
        end else if (int'(pwr_en) != m_prev) begin
            m_cnt = 0; m_ph = 0; m_prev = int'(pwr_en);
        end else if (!pwr_en) begin
            m_cnt = 0; m_ph = 0;
        end else if (t) begin
            m_cnt = 0; m_ph = (m_ph + 1) % 8;
        end else begin
            m_cnt++;
        end
        if (m_ph != old_ph) begin
            change_gap  = cycles - last_change;
            last_change = cycles;
        end
        if (cycles > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        step(3);
        // R8: reset state checked by the compare on every clock
        rst = 1'b0; cur_req = "R7"; step(5);
        cur_req = "R1"; period_ovr = 16'd4; pwr_en = 1'b1; step(90);
        cur_req = "R9"; period_ovr = 16'd1; step(30);
        cur_req = "R6"; period_ovr = 16'd3; step(7);
        pwr_en = 1'b0; step(1); pwr_en = 1'b1; step(40);
        cur_req = "R7"; pwr_en = 1'b0; step(20); pwr_en = 1'b1; step(11);
        cur_req = "R10"; period_ovr = 16'd12; step(9); period_ovr = 16'd2; step(30);
        cur_req = "R8"; period_ovr = 16'd5; step(17); rst = 1'b1; step(2); rst = 1'b0; step(50);
        // R1: default period spacing of phase changes
        cur_req = "R1"; period_ovr = '0; pwr_en = 1'b0; step(2); pwr_en = 1'b1;
        step(3 * DEF_P + 20);
        vectors++;
        if (change_gap != DEF_P) begin
            fails++; $display("FAIL R1 gap act=%0d exp=%0d", change_gap, DEF_P);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule